// File: doc/BRIEF.md
# External Clock Edge Aligner

This block runs in the local reference clock domain, at 62.5 MHz or 125 MHz. It picks one local reference edge as phase zero with respect to an external 10 MHz clock and an external pulse-per-second (PPS) input. The reference clock is 6.25 or 12.5 times faster than the external clock, so only some reference edges coincide with a 10 MHz edge. Any single coincident edge is therefore ambiguous. The block resolves this by taking the first 10 MHz rising edge that arrives strictly after a PPS rising edge.

Both external signals pass through multi-flop synchronizers and are edge-detected locally. Software raises the enable, and the block then searches for a PPS edge followed by a 10 MHz edge. When it finds that pair it emits a phase-zero strobe and sets a done flag. This search runs before the external-channel loop filter is started.

After alignment the strobe repeats on every 10 MHz edge that keeps phase zero. That is every fourth edge at the 62.5 MHz rate and every second edge at the 125 MHz rate. Both spacings equal 25 reference cycles.

Top module: `ext_edge_aligner`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `align_done` and `phase_zero` are 0.
- R2: When `align_en` is sampled low at a clock edge, `align_done` is 0 after that edge and no strobe is issued until a new alignment completes.
- R3: After enable, 10 MHz rising edges that arrive before any PPS rising edge produce neither a strobe nor done.
- R4: The alignment edge is the first 10 MHz rising edge sampled strictly after the PPS rising edge. A 10 MHz edge in the same sample as the PPS edge does not count. At the alignment edge `phase_zero` pulses for one cycle and `align_done` rises in that same cycle.
- R5: While `align_en` stays high, `align_done` stays high once set, and later PPS edges do not restart the search.
- R6: After alignment the strobe repeats on every 4th 10 MHz rising edge when `rate_sel`=0 (62.5 MHz) and on every 2nd when `rate_sel`=1 (125 MHz). Counting starts at the alignment edge. With the nominal ratios this gives 25 reference cycles between strobes.
- R7: `rate_sel` is captured at the alignment edge. Changing it later has no effect until the block is re-armed.
- R8: Dropping `align_en` and raising it again clears done and starts a new search that needs a new PPS edge.
- R9: A PPS rising edge that occurs while `align_en` is low does not count toward alignment.
- R10: With the default two synchronizer stages, suppose an external input changes before reference clock edge P0. It is acted on at edge P2, so the strobe is visible after P2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock (62.5 or 125 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| align_en | input | 1 | Arms the search while high; low clears done |
| rate_sel | input | 1 | 0: 62.5 MHz reference, 1: 125 MHz reference |
| ext_clk_in | input | 1 | External 10 MHz clock, asynchronous |
| pps_in | input | 1 | External pulse-per-second, asynchronous |
| align_done | output | 1 | Alignment found; held until enable drops |
| phase_zero | output | 1 | One-cycle strobe on each phase-zero reference edge |

## Verification
External edges reach the outputs three reference cycles after the cycle in which they are driven. Two of those cycles are the synchronizer and one is the state register. The enable reaches `align_done` one cycle after it is driven. The bench drives every input on the falling edge and keeps a short history of what it drove. It compares both outputs on every falling edge against a model that applies those delays. The first strobe after a coincident PPS and 10 MHz edge must land exactly nine cycles after the PPS was driven, at the 62.5 MHz rate. The spacing between strobes is measured and must be 25 cycles.

// File: rtl/eea_pkg.sv
package eea_pkg;

  typedef enum logic [1:0] {
    S_IDLE     = 2'd0,
    S_WAIT_PPS = 2'd1,
    S_WAIT_EXT = 2'd2,
    S_LOCKED   = 2'd3
  } eea_state_t;

  // Index of the next external edge inside one phase-zero period.
  function automatic int edge_idx_next(input int cur, input int period);
    int n;
    n = cur + 1;
    if (n >= period) n = 0;
    return n;
  endfunction

  // Edges per phase-zero period for the selected reference rate.
  function automatic int edges_per_period(input logic fast, input int slow_n, input int fast_n);
    return fast ? fast_n : slow_n;
  endfunction

endpackage

// File: rtl/eea_edge_sync.sv
module eea_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;
  logic              synced;

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], din};
      last_q <= synced;
    end
  end

  assign rise = synced & ~last_q;

  // R10: a rising edge is one cycle wide
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/eea_align_fsm.sv
module eea_align_fsm
  import eea_pkg::*;
#(
  parameter int EDGES_SLOW = 4,
  parameter int EDGES_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_en,
  input  logic rate_sel,
  input  logic ext_rise,
  input  logic pps_rise,
  output logic align_done,
  output logic phase_zero
);
  localparam int MAX_EDGES = (EDGES_SLOW > EDGES_FAST) ? EDGES_SLOW : EDGES_FAST;
  localparam int IDX_W     = (MAX_EDGES > 2) ? $clog2(MAX_EDGES) : 1;

  eea_state_t       state;
  logic             fast_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;
  logic             wrap_nxt;

  always_comb begin
    idx_nxt  = IDX_W'(edge_idx_next(int'(idx),
                      edges_per_period(fast_q, EDGES_SLOW, EDGES_FAST)));
    wrap_nxt = (idx_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      fast_q     <= 1'b0;
      idx        <= '0;
      align_done <= 1'b0;
      phase_zero <= 1'b0;
    end else begin
      phase_zero <= 1'b0;
      if (!align_en) begin
        state      <= S_IDLE;
        align_done <= 1'b0;
        idx        <= '0;
      end else begin
        case (state)
          S_IDLE:     state <= S_WAIT_PPS;
          S_WAIT_PPS: if (pps_rise) state <= S_WAIT_EXT;
          S_WAIT_EXT: if (ext_rise) begin
            state      <= S_LOCKED;
            fast_q     <= rate_sel;
            idx        <= '0;
            phase_zero <= 1'b1;
            align_done <= 1'b1;
          end
          S_LOCKED:   if (ext_rise) begin
            idx        <= idx_nxt;
            phase_zero <= wrap_nxt;
          end
          default:    state <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  en_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en |=> !align_done);
  // R4
  strobe_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_zero |-> $past(ext_rise));
  // R4
  done_rises_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_done) |-> phase_zero);
  // R3
  search_after_pps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_EXT && $past(state) != S_WAIT_EXT) |-> $past(pps_rise));
  // R5
  done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (align_done && align_en) |=> align_done);
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_zero |=> !phase_zero);
  // R7
  rate_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCKED && $past(state) == S_LOCKED) |-> $stable(fast_q));
endmodule

// File: rtl/ext_edge_aligner.sv
module ext_edge_aligner #(
  parameter int SYNC_STAGES = 2,
  parameter int EDGES_SLOW  = 4,
  parameter int EDGES_FAST  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_en,
  input  logic rate_sel,
  input  logic ext_clk_in,
  input  logic pps_in,
  output logic align_done,
  output logic phase_zero
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise_vec;
  logic            ext_rise;
  logic            pps_rise;

  assign raw_in = {pps_in, ext_clk_in};

  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_sync
      eea_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in[g]),
        .rise (rise_vec[g])
      );
    end
  endgenerate

  assign ext_rise = rise_vec[0];
  assign pps_rise = rise_vec[1];

  eea_align_fsm #(
    .EDGES_SLOW(EDGES_SLOW),
    .EDGES_FAST(EDGES_FAST)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .align_en  (align_en),
    .rate_sel  (rate_sel),
    .ext_rise  (ext_rise),
    .pps_rise  (pps_rise),
    .align_done(align_done),
    .phase_zero(phase_zero)
  );
endmodule

// File: tb/ext_edge_aligner_bench.sv
module ext_edge_aligner_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic align_en = 1'b0;
  logic rate_sel = 1'b0;
  logic ext_clk_in = 1'b0;
  logic pps_in = 1'b0;
  logic align_done;
  logic phase_zero;

  always #2 clk = ~clk;

  ext_edge_aligner u_ext_edge_aligner (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .rate_sel(rate_sel),
    .ext_clk_in(ext_clk_in), .pps_in(pps_in),
    .align_done(align_done), .phase_zero(phase_zero));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // waveform generator state
  bit ext_fast = 0;
  int pos = 0;
  // input history (values driven 1, 2, 3 steps ago)
  bit e1, e2, e3, p1, p2, p3;
  // requirement model
  int m_state = 0;
  int m_cnt = 0;
  int m_period = 4;
  bit exp_pz = 0;
  bit exp_done = 0;
  // measurement
  int step_no = 0;
  int first_pz = -1;
  int prev_pz = -1;
  int last_gap = -1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (step %0d)",
               tag, what, act, exp, step_no);
    end
  endtask

  function automatic bit ext_level(input bit fast, input int p);
    if (fast) return (p < 6) || (p >= 12 && p < 18);
    return (p % 6 < 3) && (p < 24);
  endfunction

  task automatic clear_meas();
    first_pz = -1; prev_pz = -1; last_gap = -1;
  endtask

  // One reference cycle: compare, drive, advance the model.
  task automatic step(input bit en_v, input bit pps_v, input string tag);
    bit cur_e, er, pr;
    check(phase_zero === exp_pz, tag, "phase_zero", int'(phase_zero), int'(exp_pz));
    check(align_done === exp_done, tag, "align_done", int'(align_done), int'(exp_done));
    if (phase_zero === 1'b1) begin
      if (first_pz < 0) first_pz = step_no;
      if (prev_pz >= 0) last_gap = step_no - prev_pz;
      prev_pz = step_no;
    end
    cur_e = ext_level(ext_fast, pos);
    align_en = en_v; pps_in = pps_v; ext_clk_in = cur_e;
    pos = (pos == 24) ? 0 : pos + 1;
    er = e2 && !e3;
    pr = p2 && !p3;
    exp_pz = 0;
    if (!en_v) begin
      m_state = 0; exp_done = 0; m_cnt = 0;
    end else if (m_state == 0) m_state = 1;
    else if (m_state == 1) begin
      if (pr) m_state = 2;
    end else if (m_state == 2) begin
      if (er) begin
        m_state = 3; exp_pz = 1; exp_done = 1; m_cnt = 0;
        m_period = rate_sel ? 2 : 4;
      end
    end else if (er) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == m_period) begin m_cnt = 0; exp_pz = 1; end
    end
    e3 = e2; e2 = e1; e1 = cur_e;
    p3 = p2; p2 = p1; p1 = pps_v;
    step_no++;
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit en_v, input bit pps_v, input string tag);
    for (int i = 0; i < n; i++) step(en_v, pps_v, tag);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(align_done === 1'b0, "R1", "done in reset", int'(align_done), 0);
    check(phase_zero === 1'b0, "R1", "strobe in reset", int'(phase_zero), 0);
    rst_n = 1'b1;
    run(2, 0, 0, "R1");
  endtask

  task automatic t_disabled_then_no_pps();
    clear_meas();
    run(10, 0, 0, "R9");
    run(10, 0, 1, "R9");
    run(10, 0, 0, "R9");
    run(60, 1, 0, "R3");
    check(align_done === 1'b0, "R3", "done without pps", int'(align_done), 0);
    check(first_pz == -1, "R9", "strobe seen", first_pz, -1);
  endtask

  task automatic t_align_slow();
    int s;
    clear_meas();
    while (pos != 0) step(1, 0, "R4");
    s = step_no;
    run(100, 1, 1, "R4");
    run(150, 1, 0, "R6");
    check(first_pz == s + 9, "R4", "first strobe step", first_pz, s + 9);
    check(first_pz == s + 9, "R10", "edge latency", first_pz - s - 6, 3);
    check(last_gap == 25, "R6", "slow strobe gap", last_gap, 25);
  endtask

  task automatic t_pps_again();
    clear_meas();
    run(40, 1, 1, "R5");
    run(60, 1, 0, "R5");
    check(align_done === 1'b1, "R5", "done held", int'(align_done), 1);
    check(last_gap == 25, "R5", "period after pps", last_gap, 25);
  endtask

  task automatic t_rate_change();
    clear_meas();
    rate_sel = 1'b1;
    run(120, 1, 0, "R7");
    check(last_gap == 25, "R7", "gap after rate change", last_gap, 25);
  endtask

  task automatic t_rearm_fast();
    clear_meas();
    step(0, 0, "R2");
    check(align_done === 1'b0, "R2", "done after en low", int'(align_done), 0);
    run(4, 0, 0, "R2");
    ext_fast = 1; pos = 0;
    run(10, 0, 0, "R8");
    run(40, 1, 0, "R8");
    check(align_done === 1'b0, "R8", "done before new pps", int'(align_done), 0);
    check(first_pz == -1, "R8", "strobe before pps", first_pz, -1);
    while (pos != 5) step(1, 0, "R8");
    run(60, 1, 1, "R8");
    run(140, 1, 0, "R6");
    check(align_done === 1'b1, "R8", "done after rearm", int'(align_done), 1);
    check(last_gap == 25, "R6", "fast strobe gap", last_gap, 25);
    run(3, 0, 0, "R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_disabled_then_no_pps();
    t_align_slow();
    t_pps_again();
    t_rate_change();
    t_rearm_fast();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule